// File: doc/BRIEF.md
# LIN Physical-Layer Mode Controller

This block is the digital state machine behind a single-wire LIN bus front end. It reads the host's enable, standby and transmit-data control pins together with status flags from the analog side: wake detectors, supply monitors, a battery power-on-reset comparator and a thermal sensor. From these it decides which of five operating states the front end is in. Its registered outputs drive the voltage-regulator enable, the transmitter enable, the slope-shaping select, the bus termination choice, the inhibit drive and the selector for the receive-data pin.

The three control pins are asynchronous, so each passes through a two-flop synchronizer before its edges are detected. The level of the transmit-data pin at the moment the enable pin rises chooses between full-speed and reduced-slope operation. The standby pin is captured at the same instant to decide whether the inhibit output is driven. When the enable pin falls, the standby pin selects between standby and sleep. A sticky flag records a bus wake-up so that the host can tell, from the receive pin in standby, which source woke the node.

Top module: `lin_mode_ctrl`

## Requirements
- R1: After a synchronous reset, or when the battery power-on-reset flag is released, the block is in standby (`mode_oh` = 5'b00010). In that state `reg_en`=1, `tx_en`=0, `slope_low`=0, `term_sel`=1 (weak source), `inh_drv`=0, `rxd_sel`=0 (forced high) and `bus_wake`=0.
- R2: In standby, a rising `en_pin` with `txd_pin` high enters normal mode (`mode_oh`=5'b00100). In normal mode `tx_en`=1, `slope_low`=0, `term_sel`=2 (resistor) and `rxd_sel`=2 (bus data).
- R3: In standby, a rising `en_pin` with `txd_pin` low enters low-slope mode (`mode_oh`=5'b01000, `slope_low`=1, `term_sel`=2, `rxd_sel`=2). `tx_en` stays 0 until `txd_pin` has been seen high in that mode, and is 1 afterwards.
- R4: `inh_drv` is 1 in either normal mode only when `stb_pin` was high at the entering transition; otherwise it is 0.
- R5: From either normal mode, a falling `en_pin` goes to standby when `stb_pin` is high. It goes to sleep (`mode_oh`=5'b10000) when `stb_pin` is low. In sleep `reg_en`=0, `tx_en`=0, `term_sel`=0 (none) and `rxd_sel`=0.
- R6: In sleep, a `wake_local` or `wake_bus` pulse moves the block to standby. After a local wake `rxd_sel`=0 and `bus_wake`=0. After a bus wake `rxd_sel`=1 (forced low) and `bus_wake`=1.
- R7: In standby, a `wake_bus` pulse sets `bus_wake`=1 and `rxd_sel`=1, which hold until a normal mode is entered; entry clears them. A `wake_local` pulse in standby changes no output.
- R8: `bat_uv` or `reg_uv` forces either normal mode back to standby. While either is high, a rising `en_pin` in standby is ignored.
- R9: `bat_por` high forces power-off (`mode_oh`=5'b00001) from any mode. In power-off `reg_en`=0, `tx_en`=0, `term_sel`=0, `inh_drv`=0, `rxd_sel`=0 and `bus_wake`=0.
- R10: While `therm_sd` is high, `tx_en` and `reg_en` are 0 and `mode_oh` is unchanged. Both enables return once it drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| en_pin | input | 1 | Asynchronous enable control pin |
| stb_pin | input | 1 | Asynchronous standby control pin |
| txd_pin | input | 1 | Asynchronous transmit-data pin (low = dominant) |
| wake_local | input | 1 | Debounced local wake event, synchronous |
| wake_bus | input | 1 | Qualified bus wake event, synchronous |
| bat_uv | input | 1 | Battery undervoltage flag |
| reg_uv | input | 1 | Regulator output undervoltage flag |
| bat_por | input | 1 | Battery below power-on-reset level |
| therm_sd | input | 1 | Thermal shutdown flag |
| mode_oh | output | 5 | One-hot mode: bit0 off, bit1 standby, bit2 normal, bit3 low slope, bit4 sleep |
| reg_en | output | 1 | Voltage regulator enable |
| tx_en | output | 1 | Bus transmitter enable |
| slope_low | output | 1 | Reduced slew-rate select |
| term_sel | output | 2 | Termination: 0 none, 1 weak source, 2 resistor |
| inh_drv | output | 1 | Drive inhibit output high (0 = floating) |
| rxd_sel | output | 2 | Receive pin source: 0 high, 1 low, 2 bus data |
| bus_wake | output | 1 | Sticky bus wake flag |

## Verification
The hardest situation to reach is the low-slope entry guard. It needs an enable rising edge to arrive while the synchronized transmit level is low, and the check must see the transmitter held off before the transmit level returns high. The stimulus sets the transmit pin low well before raising enable, so both synchronizers settle on consistent values. It then samples with the transmit pin still low, releases it, and samples again. The wake-source distinction is reached by a second sleep entry followed by a bus wake, after a first cycle that used a local wake. This shows the flag is produced by the wake path and is not left over from an earlier state.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;

  typedef enum logic [2:0] {
    M_OFF   = 3'd0,
    M_STBY  = 3'd1,
    M_NORM  = 3'd2,
    M_LOW   = 3'd3,
    M_SLEEP = 3'd4
  } lin_mode_e;

  localparam int MODE_COUNT = 5;

  typedef enum logic [1:0] {
    TERM_NONE = 2'd0,
    TERM_SRC  = 2'd1,
    TERM_RES  = 2'd2
  } term_e;

  typedef enum logic [1:0] {
    RX_HIGH = 2'd0,
    RX_LOW  = 2'd1,
    RX_BUS  = 2'd2
  } rxsel_e;

endpackage

// File: rtl/lin_pin_sync.sv
module lin_pin_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  localparam int PIPE_W = WIDTH * STAGES;

  logic [PIPE_W-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[PIPE_W-WIDTH-1:0], din};
      end
    end
  endgenerate

  assign dout = pipe[PIPE_W-1 -: WIDTH];

endmodule

// File: rtl/lin_edge_det.sv
module lin_edge_det #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);

  logic [WIDTH-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= lvl;
  end

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      assign rise[b] = lvl[b] & ~prev[b];
      assign fall[b] = ~lvl[b] & prev[b];
    end
  endgenerate

endmodule

// File: rtl/lin_mode_fsm.sv
module lin_mode_fsm
  import lin_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en_rise,
  input  logic      en_fall,
  input  logic      stb_s,
  input  logic      txd_s,
  input  logic      wake_local,
  input  logic      wake_bus,
  input  logic      bat_uv,
  input  logic      reg_uv,
  input  logic      bat_por,
  output lin_mode_e state,
  output logic      inh_lat,
  output logic      tx_armed,
  output logic      wake_flag
);

  lin_mode_e nxt;
  logic      uv;
  logic      in_run;

  assign uv     = bat_uv | reg_uv;
  assign in_run = (state == M_NORM) || (state == M_LOW);

  always_comb begin
    nxt = state;
    unique case (state)
      M_OFF:   nxt = M_STBY;
      M_STBY:  if (en_rise && !uv) nxt = txd_s ? M_NORM : M_LOW;
      M_NORM,
      M_LOW: begin
        if (uv)           nxt = M_STBY;
        else if (en_fall) nxt = stb_s ? M_STBY : M_SLEEP;
      end
      M_SLEEP: if (wake_local || wake_bus) nxt = M_STBY;
      default: nxt = M_STBY;
    endcase
    if (bat_por) nxt = M_OFF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= M_STBY;
      inh_lat   <= 1'b0;
      tx_armed  <= 1'b0;
      wake_flag <= 1'b0;
    end else begin
      state <= nxt;
      // INH capture on entry to a run mode, release on exit
      if (state == M_STBY && (nxt == M_NORM || nxt == M_LOW)) inh_lat <= stb_s;
      else if (nxt != M_NORM && nxt != M_LOW)                  inh_lat <= 1'b0;
      // low-slope guard: arm only after TxD seen recessive inside the mode
      if (nxt != M_LOW)                 tx_armed <= 1'b0;
      else if (state == M_LOW && txd_s) tx_armed <= 1'b1;
      // sticky wake source flag
      if (nxt == M_OFF || nxt == M_NORM || nxt == M_LOW) wake_flag <= 1'b0;
      else if ((state == M_STBY || state == M_SLEEP) && wake_bus) wake_flag <= 1'b1;
    end
  end

  AST_POR_FORCES_OFF: assert property (@(posedge clk) disable iff (rst)
    bat_por |=> (state == M_OFF)); // R9

  AST_SLEEP_WAKES: assert property (@(posedge clk) disable iff (rst)
    (state == M_SLEEP && !bat_por && (wake_local || wake_bus)) |=> (state == M_STBY)); // R6

  AST_UV_FALLBACK: assert property (@(posedge clk) disable iff (rst)
    (in_run && uv && !bat_por) |=> (state == M_STBY)); // R8

  AST_BUS_WAKE_STICKS: assert property (@(posedge clk) disable iff (rst)
    (state == M_STBY && wake_bus && !bat_por) |=> wake_flag); // R7

endmodule

// File: rtl/lin_mode_out.sv
module lin_mode_out
  import lin_mode_pkg::*;
#(
  parameter int MODE_W = MODE_COUNT
) (
  input  logic              clk,
  input  logic              rst,
  input  lin_mode_e         state_i,
  input  logic              inh_lat_i,
  input  logic              armed_i,
  input  logic              wake_flag_i,
  input  logic              therm_sd,
  output logic [MODE_W-1:0] mode_oh,
  output logic              reg_en,
  output logic              tx_en,
  output logic              slope_low,
  output logic [1:0]        term_sel,
  output logic              inh_drv,
  output logic [1:0]        rxd_sel,
  output logic              bus_wake
);

  logic run, stby, dead;

  assign run  = (state_i == M_NORM) || (state_i == M_LOW);
  assign stby = (state_i == M_STBY);
  assign dead = (state_i == M_OFF) || (state_i == M_SLEEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_oh   <= MODE_W'(1) << M_STBY;
      reg_en    <= 1'b1;
      tx_en     <= 1'b0;
      slope_low <= 1'b0;
      term_sel  <= TERM_SRC;
      inh_drv   <= 1'b0;
      rxd_sel   <= RX_HIGH;
      bus_wake  <= 1'b0;
    end else begin
      mode_oh   <= MODE_W'(1) << state_i;
      reg_en    <= !dead && !therm_sd;
      tx_en     <= ((state_i == M_NORM) || (state_i == M_LOW && armed_i)) && !therm_sd;
      slope_low <= (state_i == M_LOW);
      term_sel  <= run ? TERM_RES : (stby ? TERM_SRC : TERM_NONE);
      inh_drv   <= run && inh_lat_i;
      rxd_sel   <= run ? RX_BUS : ((stby && wake_flag_i) ? RX_LOW : RX_HIGH);
      bus_wake  <= wake_flag_i;
    end
  end

  AST_LOW_SLOPE_GUARD: assert property (@(posedge clk) disable iff (rst)
    (state_i == M_LOW && !armed_i) |=> !tx_en); // R3

  AST_THERMAL_CUTS: assert property (@(posedge clk) disable iff (rst)
    therm_sd |=> (!tx_en && !reg_en)); // R10

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state_i == M_SLEEP) |=> (!reg_en && term_sel == TERM_NONE)); // R5

  AST_INH_ONLY_RUN: assert property (@(posedge clk) disable iff (rst)
    (!run) |=> !inh_drv); // R4

endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
  import lin_mode_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MODE_W      = MODE_COUNT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_pin,
  input  logic              stb_pin,
  input  logic              txd_pin,
  input  logic              wake_local,
  input  logic              wake_bus,
  input  logic              bat_uv,
  input  logic              reg_uv,
  input  logic              bat_por,
  input  logic              therm_sd,
  output logic [MODE_W-1:0] mode_oh,
  output logic              reg_en,
  output logic              tx_en,
  output logic              slope_low,
  output logic [1:0]        term_sel,
  output logic              inh_drv,
  output logic [1:0]        rxd_sel,
  output logic              bus_wake
);

  localparam int PIN_W = 3;

  logic [PIN_W-1:0] pins_s;
  logic             en_s, stb_s, txd_s;
  logic [0:0]       en_rise, en_fall;
  lin_mode_e        state;
  logic             inh_lat, tx_armed, wake_flag;

  lin_pin_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({en_pin, stb_pin, txd_pin}),
    .dout (pins_s)
  );

  assign {en_s, stb_s, txd_s} = pins_s;

  lin_edge_det #(.WIDTH(1)) u_en_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (en_s),
    .rise (en_rise),
    .fall (en_fall)
  );

  lin_mode_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .en_rise    (en_rise[0]),
    .en_fall    (en_fall[0]),
    .stb_s      (stb_s),
    .txd_s      (txd_s),
    .wake_local (wake_local),
    .wake_bus   (wake_bus),
    .bat_uv     (bat_uv),
    .reg_uv     (reg_uv),
    .bat_por    (bat_por),
    .state      (state),
    .inh_lat    (inh_lat),
    .tx_armed   (tx_armed),
    .wake_flag  (wake_flag)
  );

  lin_mode_out #(.MODE_W(MODE_W)) u_out (
    .clk         (clk),
    .rst         (rst),
    .state_i     (state),
    .inh_lat_i   (inh_lat),
    .armed_i     (tx_armed),
    .wake_flag_i (wake_flag),
    .therm_sd    (therm_sd),
    .mode_oh     (mode_oh),
    .reg_en      (reg_en),
    .tx_en       (tx_en),
    .slope_low   (slope_low),
    .term_sel    (term_sel),
    .inh_drv     (inh_drv),
    .rxd_sel     (rxd_sel),
    .bus_wake    (bus_wake)
  );

endmodule

// File: tb/test_lin_mode_ctrl.sv
module test_lin_mode_ctrl;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_pin = 1'b0, stb_pin = 1'b0, txd_pin = 1'b1;
  logic wake_local = 1'b0, wake_bus = 1'b0;
  logic bat_uv = 1'b0, reg_uv = 1'b0, bat_por = 1'b0, therm_sd = 1'b0;
  logic [4:0] mode_oh;
  logic       reg_en, tx_en, slope_low, inh_drv, bus_wake;
  logic [1:0] term_sel, rxd_sel;

  always #10 clk = ~clk;

  lin_mode_ctrl i_lin_mode_ctrl (
    .clk(clk), .rst(rst), .en_pin(en_pin), .stb_pin(stb_pin), .txd_pin(txd_pin),
    .wake_local(wake_local), .wake_bus(wake_bus), .bat_uv(bat_uv), .reg_uv(reg_uv),
    .bat_por(bat_por), .therm_sd(therm_sd), .mode_oh(mode_oh), .reg_en(reg_en),
    .tx_en(tx_en), .slope_low(slope_low), .term_sel(term_sel), .inh_drv(inh_drv),
    .rxd_sel(rxd_sel), .bus_wake(bus_wake)
  );

  typedef struct {
    logic [13:0] exp_vec;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // expected vector: {mode5, reg, tx, slope, term2, inh, rxd2, flag}
  localparam logic [13:0] E_STBY  = {5'b00010, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 2'd0, 1'b0};
  localparam logic [13:0] E_STBYW = {5'b00010, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 2'd1, 1'b1};
  localparam logic [13:0] E_NORM  = {5'b00100, 1'b1, 1'b1, 1'b0, 2'd2, 1'b0, 2'd2, 1'b0};
  localparam logic [13:0] E_NORMI = {5'b00100, 1'b1, 1'b1, 1'b0, 2'd2, 1'b1, 2'd2, 1'b0};
  localparam logic [13:0] E_NORMT = {5'b00100, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 2'd2, 1'b0};
  localparam logic [13:0] E_LOW0  = {5'b01000, 1'b1, 1'b0, 1'b1, 2'd2, 1'b0, 2'd2, 1'b0};
  localparam logic [13:0] E_LOW1  = {5'b01000, 1'b1, 1'b1, 1'b1, 2'd2, 1'b0, 2'd2, 1'b0};
  localparam logic [13:0] E_SLEEP = {5'b10000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0};
  localparam logic [13:0] E_OFF   = {5'b00001, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0};

  // driver side: let the pins settle through sync, edge, state and output flops
  task automatic expect_out(input logic [13:0] v, input string tag);
    sb_item_t it;
    repeat (8) @(negedge clk);
    it.exp_vec = v;
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic pulse_wake(input bit bus);
    @(negedge clk);
    if (bus) wake_bus = 1'b1; else wake_local = 1'b1;
    @(negedge clk);
    wake_bus = 1'b0;
    wake_local = 1'b0;
  endtask

  // monitor side
  initial begin
    forever begin
      sb_item_t it;
      logic [13:0] act;
      wait (sb_q.size() != 0);
      it = sb_q.pop_front();
      act = {mode_oh, reg_en, tx_en, slope_low, term_sel, inh_drv, rxd_sel, bus_wake};
      checks++;
      if (act !== it.exp_vec) begin
        failures++;
        $display("FAIL %s actual=%b expected=%b", it.tag, act, it.exp_vec);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expect_out(E_STBY, "R1 reset enters standby");

    txd_pin = 1'b1; stb_pin = 1'b1;
    @(negedge clk); en_pin = 1'b1;
    expect_out(E_NORMI, "R2 R4 normal with INH");

    en_pin = 1'b0;
    expect_out(E_STBY, "R5 EN fall with STB high to standby");

    stb_pin = 1'b0; txd_pin = 1'b0;
    @(negedge clk); en_pin = 1'b1;
    expect_out(E_LOW0, "R3 R4 low slope entry holds tx off");
    txd_pin = 1'b1;
    expect_out(E_LOW1, "R3 tx enabled after TxD high");

    en_pin = 1'b0;
    expect_out(E_SLEEP, "R5 EN fall with STB low to sleep");

    pulse_wake(1'b0);
    expect_out(E_STBY, "R6 local wake to standby rxd high");
    pulse_wake(1'b0);
    expect_out(E_STBY, "R7 local wake in standby ignored");
    pulse_wake(1'b1);
    expect_out(E_STBYW, "R7 bus wake in standby holds rxd low");

    @(negedge clk); en_pin = 1'b1;
    expect_out(E_NORM, "R7 normal entry clears wake flag");

    bat_uv = 1'b1;
    expect_out(E_STBY, "R8 battery undervoltage fallback");
    en_pin = 1'b0;
    expect_out(E_STBY, "R8 EN fall in standby no change");
    en_pin = 1'b1;
    expect_out(E_STBY, "R8 EN rise ignored under undervoltage");
    en_pin = 1'b0;
    bat_uv = 1'b0;
    repeat (4) @(negedge clk);
    en_pin = 1'b1;
    expect_out(E_NORM, "R2 normal again");

    therm_sd = 1'b1;
    expect_out(E_NORMT, "R10 thermal cuts enables keeps mode");
    therm_sd = 1'b0;
    expect_out(E_NORM, "R10 enables restored");

    en_pin = 1'b0;
    expect_out(E_SLEEP, "R5 sleep second entry");
    pulse_wake(1'b1);
    expect_out(E_STBYW, "R6 bus wake from sleep rxd low");

    bat_por = 1'b1;
    expect_out(E_OFF, "R9 power-off");
    bat_por = 1'b0;
    expect_out(E_STBY, "R1 R9 power-up to standby");

    txd_pin = 1'b0;
    @(negedge clk); en_pin = 1'b1;
    expect_out(E_LOW0, "R3 low slope again");
    reg_uv = 1'b1;
    expect_out(E_STBY, "R8 regulator undervoltage fallback");
    reg_uv = 1'b0;

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule